// File: doc/BRIEF.md
# Line blanking sequence generator

This block is the horizontal timing engine for a frame-transfer image sensor. A free-running pixel counter sets the position within each line. The counter advances on every clock where the pixel-clock enable is high, and it restarts at zero after the last count. All edges of the phase and strobe outputs sit at fixed counts inside the blanking interval. In that interval the block:

- moves one line from the storage area into the horizontal register, using the four storage phases;
- runs one back-and-forth charge-pump step on the four image phases, which limits dark current;
- drives the blanking strobes that a camera's video chain and register-clock driver use.

A shutter request adds a charge-reset pulse. The request must be seen early in the line. The pulse overlaps the pump step and shortens the effective integration time.

A two-bit line kind is sampled at each line wrap and applies to the whole next line:

| Code | Kind | Effect |
|------|------|--------|
| 0 | readout | normal blanking sequence |
| 1 | clamp | readout, plus the black-level clamp strobe |
| 2 | frame transfer | vertical phases stay at rest, so other logic can drive the bulk shift |
| 3 | frame transfer | same as code 2 |

A one-clock line-start pulse marks each wrap for the frame-level sequencer.

Top module: `line_blank_gen`

## Requirements
- R1: The count resets to 0. It advances by one only on clocks where `pix_en_i` is high, and it returns to 0 after count `LINE_LEN-1` (default 1152 counts per line).
- R2: `line_start_o` is high for exactly one clock, the clock after a wrap edge. `line_kind_i` is sampled on that same wrap edge. Its code (0 readout, 1 clamp, 2 or 3 frame transfer) governs the whole following line. After reset the kind is readout.
- R3: `reg_stop_o` is high for counts 0 to 71 and low otherwise.
- R4: `img_ph_o` bit 0 is the first image phase and bit 3 is the fourth. The resting level is 4'b0011. On readout and clamp lines:
  - bit 0 is low for counts 28 to 54;
  - bit 2 is high for counts 19 to 63;
  - bit 3 is high for counts 37 to 45;
  - bit 1 is always high.
  On frame-transfer lines the phases stay at 4'b0011. At least two phases are high at every count.
- R5: `stor_ph_o` bit 0 is the first storage phase. On readout and clamp lines each bit is high over the range of counts below and low otherwise. On frame-transfer lines all four bits stay low.

  | Bit | High for counts |
  |-----|-----------------|
  | 0 | 20 to 49 |
  | 1 | 32 to 61 |
  | 2 | 26 to 43 |
  | 3 | 38 to 55 |

- R6: The shutter is armed when `shutter_req_i` is high on any clock edge at which the count is below 19. Once armed, `shut_reset_o` is high for counts 19 to 63 (45 counts) of that line. A request seen at count 19 or later has no effect on that line. The arming is cleared at the wrap.
- R7: `shut_reset_o` stays low during frame-transfer lines, even when the shutter is armed.
- R8: `pre_blank_o` is high for counts 0 to 78. `clamp_o` is high for counts 72 to 78, and only on clamp lines.
- R9: `comp_blank_o` is high for counts 1131 and above and for counts 0 to 98, so the window spans the wrap.
- R10: While reset is held, the count is 0, the kind is readout, the shutter is not armed and `line_start_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel-clock enable; the count advances when high |
| shutter_req_i | input | 1 | Request for a charge-reset pulse on the current line |
| line_kind_i | input | 2 | Kind for the next line: 0 readout, 1 clamp, 2 or 3 frame transfer |
| img_ph_o | output | 4 | Image-area phase levels, bit 0 = first phase |
| stor_ph_o | output | 4 | Storage-area phase levels, bit 0 = first phase |
| reg_stop_o | output | 1 | Horizontal register clocks held stopped |
| pre_blank_o | output | 1 | Pre-blanking strobe |
| clamp_o | output | 1 | Black-level clamp strobe |
| comp_blank_o | output | 1 | Composite blanking strobe |
| shut_reset_o | output | 1 | Charge-reset pulse for the electronic shutter |
| line_start_o | output | 1 | One-clock pulse after each line wrap |

## Verification
All outputs are decoded from the count, the latched kind and the shutter arming. A count that slips or that moves while the enable is low therefore shows up at the next phase or strobe edge in the line: at most about 1000 counts later, and within 72 counts for the edges clustered in blanking. A wrong latched kind shows as missing or spurious storage pulses, pump edges or clamp on the very next line. A wrongly held or cleared shutter arming shows as a missing or extra 45-count reset pulse at count 19 of the affected line. The bench compares every output at every count of several full lines against values derived from the requirements. It also covers the shutter boundary at counts 18 and 19 and a stall of the enable.

// File: rtl/lbg_pkg.sv
package lbg_pkg;
  typedef enum logic [1:0] {
    KIND_READ      = 2'b00,
    KIND_CLAMP     = 2'b01,
    KIND_FRAME     = 2'b10,
    KIND_FRAME_ALT = 2'b11
  } line_kind_e;
endpackage

// File: rtl/lbg_line_counter.sv
module lbg_line_counter #(
  parameter int unsigned LINE_LEN = 1152,
  parameter int unsigned CW       = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o,
  output logic          line_start_o
);
  localparam logic [CW-1:0] LAST = CW'(LINE_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          ls_q;

  assign wrap_o       = en_i && (cnt_q == LAST);
  assign cnt_o        = cnt_q;
  assign line_start_o = ls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ls_q  <= 1'b0;
    end else begin
      ls_q <= wrap_o;
      if (en_i) cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
    end
  end

  assert_cnt_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_hold_when_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
  assert_start_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ls_q |=> !ls_q);
endmodule

// File: rtl/lbg_window.sv
module lbg_window #(
  parameter int unsigned CW   = 11,
  parameter int unsigned LO   = 0,
  parameter int unsigned HI   = 1,
  parameter bit          WRAP = 1'b0
) (
  input  logic [CW-1:0] cnt_i,
  output logic          hit_o
);
  localparam logic [CW-1:0] LO_C = CW'(LO);
  localparam logic [CW-1:0] HI_C = CW'(HI);

  generate
    if (WRAP) begin : g_wrap
      assign hit_o = (cnt_i >= LO_C) || (cnt_i < HI_C);
    end else if (LO == 0) begin : g_head
      assign hit_o = cnt_i < HI_C;
    end else begin : g_span
      assign hit_o = (cnt_i >= LO_C) && (cnt_i < HI_C);
    end
  endgenerate
endmodule

// File: rtl/lbg_shutter_arm.sv
module lbg_shutter_arm #(
  parameter int unsigned CW       = 11,
  parameter int unsigned CR_START = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic          wrap_i,
  input  logic          req_i,
  output logic          arm_o
);
  localparam logic [CW-1:0] START_C = CW'(CR_START);

  logic arm_q;
  assign arm_o = arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         arm_q <= 1'b0;
    else if (wrap_i)                     arm_q <= 1'b0;
    else if (req_i && (cnt_i < START_C)) arm_q <= 1'b1;
  end

  assert_arm_cleared_at_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> !arm_q);
endmodule

// File: rtl/line_blank_gen.sv
module line_blank_gen
  import lbg_pkg::*;
#(
  parameter int unsigned LINE_LEN      = 1152,
  parameter int unsigned REG_STOP_END  = 72,
  parameter int unsigned PUMP_EDGE [6] = '{19, 28, 37, 46, 55, 64},
  parameter int unsigned STOR_RISE [4] = '{20, 32, 26, 38},
  parameter int unsigned STOR_FALL [4] = '{50, 62, 44, 56},
  parameter int unsigned CR_START      = 19,
  parameter int unsigned CR_LEN        = 45,
  parameter int unsigned PB_END        = 79,
  parameter int unsigned CLAMP_START   = 72,
  parameter int unsigned CB_START      = 1131,
  parameter int unsigned CB_END        = 99
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pix_en_i,
  input  logic       shutter_req_i,
  input  logic [1:0] line_kind_i,
  output logic [3:0] img_ph_o,
  output logic [3:0] stor_ph_o,
  output logic       reg_stop_o,
  output logic       pre_blank_o,
  output logic       clamp_o,
  output logic       comp_blank_o,
  output logic       shut_reset_o,
  output logic       line_start_o
);
  localparam int unsigned CW = $clog2(LINE_LEN);

  logic [CW-1:0] cnt;
  logic          wrap;
  logic          armed;
  line_kind_e    kind_q;
  logic          frame_line;

  lbg_line_counter #(.LINE_LEN(LINE_LEN), .CW(CW)) u_cnt (
    .clk_i, .rst_ni, .en_i(pix_en_i), .cnt_o(cnt), .wrap_o(wrap),
    .line_start_o(line_start_o)
  );

  lbg_shutter_arm #(.CW(CW), .CR_START(CR_START)) u_arm (
    .clk_i, .rst_ni, .cnt_i(cnt), .wrap_i(wrap), .req_i(shutter_req_i),
    .arm_o(armed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   kind_q <= KIND_READ;
    else if (wrap) kind_q <= line_kind_e'(line_kind_i);
  end

  assign frame_line = (kind_q == KIND_FRAME) || (kind_q == KIND_FRAME_ALT);

  // pump: step charge forward half a phase, then back to rest under phases 1,2
  logic a1_low, a3_high, a4_high;
  lbg_window #(.CW(CW), .LO(PUMP_EDGE[1]), .HI(PUMP_EDGE[4])) u_a1 (.cnt_i(cnt), .hit_o(a1_low));
  lbg_window #(.CW(CW), .LO(PUMP_EDGE[0]), .HI(PUMP_EDGE[5])) u_a3 (.cnt_i(cnt), .hit_o(a3_high));
  lbg_window #(.CW(CW), .LO(PUMP_EDGE[2]), .HI(PUMP_EDGE[3])) u_a4 (.cnt_i(cnt), .hit_o(a4_high));

  assign img_ph_o = frame_line ? 4'b0011 : {a4_high, a3_high, 1'b1, ~a1_low};

  logic [3:0] stor_win;
  for (genvar i = 0; i < 4; i++) begin : g_stor
    lbg_window #(.CW(CW), .LO(STOR_RISE[i]), .HI(STOR_FALL[i])) u_b (
      .cnt_i(cnt), .hit_o(stor_win[i])
    );
  end
  assign stor_ph_o = frame_line ? 4'b0000 : stor_win;

  logic ssc_win, pb_win, clamp_win, cb_win, cr_win;
  lbg_window #(.CW(CW), .LO(0), .HI(REG_STOP_END)) u_ssc (.cnt_i(cnt), .hit_o(ssc_win));
  lbg_window #(.CW(CW), .LO(0), .HI(PB_END)) u_pb (.cnt_i(cnt), .hit_o(pb_win));
  lbg_window #(.CW(CW), .LO(CLAMP_START), .HI(PB_END)) u_clamp (.cnt_i(cnt), .hit_o(clamp_win));
  lbg_window #(.CW(CW), .LO(CB_START), .HI(CB_END), .WRAP(1'b1)) u_cb (.cnt_i(cnt), .hit_o(cb_win));
  lbg_window #(.CW(CW), .LO(CR_START), .HI(CR_START + CR_LEN)) u_cr (.cnt_i(cnt), .hit_o(cr_win));

  assign reg_stop_o   = ssc_win;
  assign pre_blank_o  = pb_win;
  assign clamp_o      = clamp_win && (kind_q == KIND_CLAMP);
  assign comp_blank_o = cb_win;
  assign shut_reset_o = cr_win && armed && !frame_line;

  assert_pump_two_phases_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(img_ph_o) >= 2);
  assert_cr_starts_on_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shut_reset_o) |-> (cnt == CW'(CR_START)));
  assert_no_cr_on_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shut_reset_o |-> (stor_ph_o != 4'b0000 || img_ph_o != 4'b0011));
  assert_clamp_inside_blank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_o |-> (pre_blank_o && !reg_stop_o && comp_blank_o));
endmodule

// File: tb/line_blank_gen_bench.sv
module line_blank_gen_bench;
  localparam int LINE_LEN = 1152;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       pix_en;
  logic       shut_req;
  logic [1:0] kind_in;
  logic [3:0] img_ph, stor_ph;
  logic       reg_stop, pre_blank, clamp, comp_blank, shut_reset, line_start;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  line_blank_gen u_line_blank_gen (
    .clk_i(clk), .rst_ni(rst_ni), .pix_en_i(pix_en), .shutter_req_i(shut_req),
    .line_kind_i(kind_in), .img_ph_o(img_ph), .stor_ph_o(stor_ph),
    .reg_stop_o(reg_stop), .pre_blank_o(pre_blank), .clamp_o(clamp),
    .comp_blank_o(comp_blank), .shut_reset_o(shut_reset), .line_start_o(line_start)
  );

  // reference state from the requirements
  int         m_cnt;
  logic [1:0] m_kind;
  bit         m_arm;
  bit         m_ls;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt <= 0; m_kind <= 2'd0; m_arm <= 0; m_ls <= 0;
    end else begin
      m_ls <= pix_en && (m_cnt == LINE_LEN - 1);
      if (pix_en && m_cnt == LINE_LEN - 1) begin
        m_cnt  <= 0;
        m_kind <= kind_in;
        m_arm  <= 0;
      end else begin
        if (pix_en) m_cnt <= m_cnt + 1;
        if (shut_req && m_cnt < 19) m_arm <= 1;
      end
    end
  end

  function automatic bit in_w(int c, int lo, int hi);
    return (c >= lo) && (c < hi);
  endfunction

  task automatic chk(string req, string ctx, logic [3:0] act, logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s (%s) count=%0d actual=%b expected=%b", req, ctx, m_cnt, act, exp);
    end
  endtask

  task automatic check_all(string ctx);
    int  c     = m_cnt;
    bit  frame = m_kind[1];
    logic [3:0] e_img, e_stor;
    e_img  = frame ? 4'b0011 :
             {in_w(c, 37, 46), in_w(c, 19, 64), 1'b1, !in_w(c, 28, 55)};
    e_stor = frame ? 4'b0000 :
             {in_w(c, 38, 56), in_w(c, 26, 44), in_w(c, 32, 62), in_w(c, 20, 50)};
    chk("R4", ctx, img_ph, e_img);
    chk("R5", ctx, stor_ph, e_stor);
    chk("R3", ctx, {3'b0, reg_stop}, {3'b0, c < 72});
    chk("R8", ctx, {3'b0, pre_blank}, {3'b0, c < 79});
    chk("R8", ctx, {3'b0, clamp}, {3'b0, (m_kind == 2'd1) && in_w(c, 72, 79)});
    chk("R9", ctx, {3'b0, comp_blank}, {3'b0, (c >= 1131) || (c < 99)});
    chk(frame ? "R7" : "R6", ctx, {3'b0, shut_reset},
        {3'b0, m_arm && !frame && in_w(c, 19, 64)});
    chk("R2", ctx, {3'b0, line_start}, {3'b0, m_ls});
  endtask

  // one check per clock; the shutter is requested while the count is in [sh_lo, sh_hi)
  task automatic run_ticks(int n, logic [1:0] next_kind, int sh_lo, int sh_hi, string ctx);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all(ctx);
      kind_in  = next_kind;
      shut_req = in_w(m_cnt, sh_lo, sh_hi);
    end
  endtask

  task automatic test_reset();
    rst_ni = 0; pix_en = 0; shut_req = 0; kind_in = 2'd0;
    repeat (3) @(negedge clk);
    check_all("R10 during reset");
    chk("R10", "count 0 after reset", {3'b0, reg_stop && comp_blank}, 4'b0001);
    rst_ni = 1;
    @(negedge clk);
    check_all("R10 after release");
  endtask

  task automatic test_readout_line();
    pix_en = 1;
    run_ticks(LINE_LEN, 2'd1, 0, 0, "R1 readout line, no shutter");
  endtask

  task automatic test_clamp_shutter();
    run_ticks(LINE_LEN, 2'd2, 3, 6, "R6 clamp line, early shutter");
  endtask

  task automatic test_frame_line();
    run_ticks(LINE_LEN, 2'd0, 0, 11, "R7 frame line, shutter ignored");
  endtask

  task automatic test_late_shutter();
    run_ticks(LINE_LEN, 2'd3, 19, 41, "R6 late shutter ignored");
    run_ticks(LINE_LEN, 2'd0, 0, 0, "R7 frame code 3");
  endtask

  task automatic test_shutter_edges();
    run_ticks(LINE_LEN, 2'd0, 18, 19, "R6 request at count 18");
    run_ticks(LINE_LEN, 2'd0, 19, 20, "R6 request at count 19");
  endtask

  task automatic test_stall();
    run_ticks(30, 2'd0, 0, 0, "R1 before stall");
    pix_en = 0;
    run_ticks(20, 2'd0, 5, 1000, "R1 stall holds count");
    pix_en = 1;
    run_ticks(LINE_LEN - 30, 2'd1, 0, 0, "R1 after stall");
    run_ticks(2, 2'd1, 0, 0, "R2 start pulse");
  endtask

  initial begin
    test_reset();
    test_readout_line();
    test_clamp_shutter();
    test_frame_line();
    test_late_shutter();
    test_shutter_edges();
    test_stall();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule